// File: doc/BRIEF.md
# Product-Term Expander Slice

This block is one logic-array slice of eight macrocells that share one programmable AND array. Every macrocell owns five product terms. A per-term routing bit sends each term either into the macrocell's OR gate or to a dedicated secondary role: register clear, preset, clock, clock enable, or, for the fifth term, a shareable expander. A shareable expander is inverted and fed back as an extra literal that every product term in the slice may use.

A macrocell can also lend its whole set of five terms up a one-way chain to the next higher-numbered macrocell. A lender passes on whatever it has borrowed as well. Up to three consecutive lenders may feed one receiver, so a single output can collect twenty terms.

The array inputs and the static configuration come in as flat vectors. The eight sums, the four register controls per macrocell and a configuration-error flag are registered once before they leave the block. A configuration check flags settings that the chain or the feedback cannot honour.

Top module: `pte_expander_slice`

## Requirements
- R1: Literal i of the AND array is `array_in[i]` for i < NIN and expander line i-NIN otherwise. Fuse bit 2i selects literal i true and bit 2i+1 selects it complemented. The fuse field of term k of macrocell m starts at bit (m*5+k)*2*(NIN+NMC). A term is 1 only when at least one fuse is set and every selected literal is satisfied; a term with no fuse set is 0.
- R2: Routing bit m*5+k set diverts term k of macrocell m from the OR gate to a secondary role: k=0 clear, k=1 preset, k=2 clock, k=3 clock enable. An undiverted control output idles at 0, except clock enable, which idles at 1.
- R3: With routing bit m*5+4 set, term 4 of macrocell m drives expander line m as its complement, evaluated over the primary inputs only. Otherwise expander line m is held at 1.
- R4: `pol_inv[m]` set inverts the OR result of macrocell m.
- R5: A lending macrocell (`lend_en[m]`) passes the OR of all five of its terms, together with anything it has borrowed, to macrocell m+1. Its own sum becomes the bare polarity bit.
- R6: A receiver ORs its own undiverted terms with all terms of the contiguous run of lenders directly below it, up to three lenders (twenty terms).
- R7: `cfg_err` is raised when any of these holds: the top macrocell lends; a lender has a routing bit set; more than three consecutive macrocells lend; or a shared term 4 has an expander-line fuse set.
- R8: All outputs are registered, one cycle after the inputs. Asynchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| array_in | input | NIN | Primary array inputs |
| fuse_map | input | NMC*5*2*(NIN+NMC) | AND-array fuses for all terms |
| route_sel | input | NMC*5 | Per-term secondary routing bits |
| lend_en | input | NMC | Lend whole term set to next macrocell |
| pol_inv | input | NMC | Output polarity inversion |
| mc_sum | output | NMC | Registered macrocell sums |
| reg_clr | output | NMC | Registered clear term per macrocell |
| reg_pre | output | NMC | Registered preset term per macrocell |
| reg_clk | output | NMC | Registered clock term per macrocell |
| reg_ce | output | NMC | Registered clock-enable term per macrocell |
| cfg_err | output | 1 | Registered illegal-configuration flag |

## Verification
The assertion on lender sums relies on the configuration being legal in the same cycle. The rule that an error always follows a feedback loop assumes a shared term draws on primary inputs only, and the sums have a defined meaning only under that assumption. The random stimulus therefore builds legal settings only. It keeps lender runs to three, keeps the top macrocell from lending, keeps a lender's routing bits at zero and gives shared terms input literals only. Illegal settings are applied as separate directed cycles, and for those cycles only the error flag is compared.

// File: rtl/pte_pkg.sv
package pte_pkg;
  localparam int PT_PER_MC   = 5;
  localparam int MAX_LENDERS = 3;
  localparam int ROLE_CLR    = 0;
  localparam int ROLE_PRE    = 1;
  localparam int ROLE_CLK    = 2;
  localparam int ROLE_CE     = 3;
  localparam int ROLE_SHR    = 4;

  typedef struct packed {
    logic clr;
    logic pre;
    logic clk;
    logic ce;
  } reg_ctl_t;
endpackage

// File: rtl/pte_and_plane.sv
module pte_and_plane #(
  parameter int NLIT = 14
) (
  input  logic [NLIT-1:0]   lit,
  input  logic [2*NLIT-1:0] fuse,
  output logic              term
);
  // A term with no fuse blown-in is inactive; otherwise AND of chosen literals.
  function automatic logic eval_term(logic [NLIT-1:0] l, logic [2*NLIT-1:0] f);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < NLIT; i++) begin
      if (f[2*i]   && !l[i]) hit = 1'b0;
      if (f[2*i+1] &&  l[i]) hit = 1'b0;
    end
    return hit && (f != '0);
  endfunction

  assign term = eval_term(lit, fuse);
endmodule

// File: rtl/pte_cell.sv
module pte_cell
  import pte_pkg::*;
#(
  parameter int NLIT = 14
) (
  input  logic [NLIT-1:0]              lit,
  input  logic [PT_PER_MC*2*NLIT-1:0]  fuses,
  input  logic [PT_PER_MC-1:0]         route,
  output logic                         or_own,
  output logic                         or_all,
  output reg_ctl_t                     ctl
);
  localparam int FW = 2 * NLIT;

  logic [PT_PER_MC-1:0] terms;

  for (genvar k = 0; k < PT_PER_MC; k++) begin : g_term
    pte_and_plane #(.NLIT(NLIT)) u_plane (
      .lit  (lit),
      .fuse (fuses[k*FW +: FW]),
      .term (terms[k])
    );
  end

  assign or_own  = |(terms & ~route);
  assign or_all  = |terms;
  assign ctl.clr = route[ROLE_CLR] & terms[ROLE_CLR];
  assign ctl.pre = route[ROLE_PRE] & terms[ROLE_PRE];
  assign ctl.clk = route[ROLE_CLK] & terms[ROLE_CLK];
  assign ctl.ce  = route[ROLE_CE] ? terms[ROLE_CE] : 1'b1;
endmodule

// File: rtl/pte_chain.sv
module pte_chain #(
  parameter int NMC = 8
) (
  input  logic [NMC-1:0] lend_en,
  input  logic [NMC-1:0] or_own,
  input  logic [NMC-1:0] or_all,
  input  logic [NMC-1:0] pol_inv,
  output logic [NMC-1:0] sum,
  output logic [NMC-1:0] borrowed
);
  logic brw [NMC+1];
  logic spill_unused;

  assign brw[0] = 1'b0;
  for (genvar m = 0; m < NMC; m++) begin : g_link
    // lender forwards its full set plus whatever it received
    assign brw[m+1]    = lend_en[m] ? (or_all[m] | brw[m]) : 1'b0;
    assign borrowed[m] = brw[m];
    assign sum[m]      = pol_inv[m] ^ (lend_en[m] ? 1'b0 : (or_own[m] | brw[m]));
  end
  assign spill_unused = brw[NMC];
endmodule

// File: rtl/pte_cfg_check.sv
module pte_cfg_check
  import pte_pkg::*;
#(
  parameter int NMC = 8
) (
  input  logic [NMC-1:0]           lend_en,
  input  logic [NMC*PT_PER_MC-1:0] route_sel,
  input  logic [NMC*2*NMC-1:0]     shr_xfuse,
  output logic                     err_top,
  output logic                     err_mix,
  output logic                     err_depth,
  output logic                     err_loop,
  output logic                     err_any
);
  function automatic logic run_too_long(logic [NMC-1:0] l);
    int run;
    logic bad;
    run = 0;
    bad = 1'b0;
    for (int m = 0; m < NMC; m++) begin
      run = l[m] ? run + 1 : 0;
      if (run > MAX_LENDERS) bad = 1'b1;
    end
    return bad;
  endfunction

  logic [NMC-1:0] mix_v;
  logic [NMC-1:0] loop_v;

  for (genvar m = 0; m < NMC; m++) begin : g_mc
    assign mix_v[m]  = lend_en[m] & (|route_sel[m*PT_PER_MC +: PT_PER_MC]);
    assign loop_v[m] = route_sel[m*PT_PER_MC + ROLE_SHR] & (|shr_xfuse[m*2*NMC +: 2*NMC]);
  end

  assign err_top   = lend_en[NMC-1];
  assign err_mix   = |mix_v;
  assign err_depth = run_too_long(lend_en);
  assign err_loop  = |loop_v;
  assign err_any   = err_top | err_mix | err_depth | err_loop;
endmodule

// File: rtl/pte_expander_slice.sv
module pte_expander_slice
  import pte_pkg::*;
#(
  parameter int NIN = 6,
  parameter int NMC = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NIN-1:0]                         array_in,
  input  logic [NMC*PT_PER_MC*2*(NIN+NMC)-1:0]   fuse_map,
  input  logic [NMC*PT_PER_MC-1:0]               route_sel,
  input  logic [NMC-1:0]                         lend_en,
  input  logic [NMC-1:0]                         pol_inv,
  output logic [NMC-1:0]                         mc_sum,
  output logic [NMC-1:0]                         reg_clr,
  output logic [NMC-1:0]                         reg_pre,
  output logic [NMC-1:0]                         reg_clk,
  output logic [NMC-1:0]                         reg_ce,
  output logic                                   cfg_err
);
  localparam int NLIT  = NIN + NMC;
  localparam int FW    = 2 * NLIT;
  localparam int CELLW = PT_PER_MC * FW;

  logic [NMC-1:0]       shr_term;
  logic [NMC-1:0]       xline;
  logic [NLIT-1:0]      lit_bus;
  logic [NMC-1:0]       or_own;
  logic [NMC-1:0]       or_all;
  logic [NMC-1:0]       sum_d;
  logic [NMC-1:0]       borrowed;
  logic [NMC*2*NMC-1:0] shr_xfuse;
  reg_ctl_t             ctl [NMC];
  logic                 err_top, err_mix, err_depth, err_loop, err_any;

  // shareable expanders see primary inputs only, so feedback cannot loop
  for (genvar j = 0; j < NMC; j++) begin : g_share
    localparam int SBASE = (j*PT_PER_MC + ROLE_SHR) * FW;
    pte_and_plane #(.NLIT(NIN)) u_shr (
      .lit  (array_in),
      .fuse (fuse_map[SBASE +: 2*NIN]),
      .term (shr_term[j])
    );
    assign xline[j] = route_sel[j*PT_PER_MC + ROLE_SHR] ? ~shr_term[j] : 1'b1;
    assign shr_xfuse[j*2*NMC +: 2*NMC] = fuse_map[SBASE + 2*NIN +: 2*NMC];
  end

  assign lit_bus = {xline, array_in};

  for (genvar m = 0; m < NMC; m++) begin : g_cell
    pte_cell #(.NLIT(NLIT)) u_cell (
      .lit    (lit_bus),
      .fuses  (fuse_map[m*CELLW +: CELLW]),
      .route  (route_sel[m*PT_PER_MC +: PT_PER_MC]),
      .or_own (or_own[m]),
      .or_all (or_all[m]),
      .ctl    (ctl[m])
    );
  end

  pte_chain #(.NMC(NMC)) u_chain (
    .lend_en  (lend_en),
    .or_own   (or_own),
    .or_all   (or_all),
    .pol_inv  (pol_inv),
    .sum      (sum_d),
    .borrowed (borrowed)
  );

  pte_cfg_check #(.NMC(NMC)) u_check (
    .lend_en   (lend_en),
    .route_sel (route_sel),
    .shr_xfuse (shr_xfuse),
    .err_top   (err_top),
    .err_mix   (err_mix),
    .err_depth (err_depth),
    .err_loop  (err_loop),
    .err_any   (err_any)
  );

  logic borrowed_unused;
  assign borrowed_unused = |borrowed | err_top | err_mix | err_depth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_sum  <= '0;
      reg_clr <= '0;
      reg_pre <= '0;
      reg_clk <= '0;
      reg_ce  <= '0;
      cfg_err <= 1'b0;
    end else begin
      mc_sum  <= sum_d;
      cfg_err <= err_any;
      for (int m = 0; m < NMC; m++) begin
        reg_clr[m] <= ctl[m].clr;
        reg_pre[m] <= ctl[m].pre;
        reg_clk[m] <= ctl[m].clk;
        reg_ce[m]  <= ctl[m].ce;
      end
    end
  end
endmodule

// File: rtl/pte_expander_slice_chk.sv
module pte_expander_slice_chk
  import pte_pkg::*;
#(
  parameter int NIN = 6,
  parameter int NMC = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NMC*PT_PER_MC-1:0] route_sel,
  input logic [NMC-1:0]           lend_en,
  input logic [NMC-1:0]           pol_inv,
  input logic [NMC-1:0]           mc_sum,
  input logic [NMC-1:0]           reg_clr,
  input logic [NMC-1:0]           reg_pre,
  input logic [NMC-1:0]           reg_clk,
  input logic [NMC-1:0]           reg_ce,
  input logic                     cfg_err,
  input logic                     share_loop,
  input logic                     comb_err
);
  // lender output collapses to its polarity bit
  for (genvar m = 0; m < NMC; m++) begin : g_lend
    assert_lender_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!comb_err && lend_en[m]) |=> (mc_sum[m] == $past(pol_inv[m])));
  end

  assert_top_lend_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lend_en[NMC-1] |=> cfg_err);

  assert_no_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    share_loop |=> cfg_err);

  for (genvar g = 0; g + MAX_LENDERS < NMC; g++) begin : g_depth
    assert_depth_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (&lend_en[g +: MAX_LENDERS+1]) |=> cfg_err);
  end

  assert_ctrl_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel == '0) |=> (reg_clr == '0 && reg_pre == '0 && reg_clk == '0 && reg_ce == '1));

  logic nin_unused;
  assign nin_unused = (NIN > 0);
endmodule

bind pte_expander_slice pte_expander_slice_chk #(.NIN(NIN), .NMC(NMC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .route_sel  (route_sel),
  .lend_en    (lend_en),
  .pol_inv    (pol_inv),
  .mc_sum     (mc_sum),
  .reg_clr    (reg_clr),
  .reg_pre    (reg_pre),
  .reg_clk    (reg_clk),
  .reg_ce     (reg_ce),
  .cfg_err    (cfg_err),
  .share_loop (err_loop),
  .comb_err   (err_any)
);

// File: tb/pte_expander_slice_bench.sv
module pte_expander_slice_bench;
  import pte_pkg::*;

  localparam int NIN  = 6;
  localparam int NMC  = 8;
  localparam int NLIT = NIN + NMC;
  localparam int FW   = 2 * NLIT;
  localparam int NT   = NMC * PT_PER_MC;
  localparam int MW   = NT * FW;

  typedef struct {
    logic [NMC-1:0] sum, clr, pre, clkc, ce;
    logic           err;
    logic           full;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIN-1:0] array_in = '0;
  logic [MW-1:0]  fuse_map = '0;
  logic [NT-1:0]  route_sel = '0;
  logic [NMC-1:0] lend_en = '0;
  logic [NMC-1:0] pol_inv = '0;
  logic [NMC-1:0] mc_sum, reg_clr, reg_pre, reg_clk, reg_ce;
  logic           cfg_err;

  logic [NIN-1:0] nx_in;
  logic [MW-1:0]  nx_fuse;
  logic [NT-1:0]  nx_route;
  logic [NMC-1:0] nx_lend;
  logic [NMC-1:0] nx_pol;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  pte_expander_slice #(.NIN(NIN), .NMC(NMC)) u_pte_expander_slice (
    .clk(clk), .rst_n(rst_n), .array_in(array_in), .fuse_map(fuse_map),
    .route_sel(route_sel), .lend_en(lend_en), .pol_inv(pol_inv),
    .mc_sum(mc_sum), .reg_clr(reg_clr), .reg_pre(reg_pre),
    .reg_clk(reg_clk), .reg_ce(reg_ce), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [NMC-1:0] act, input logic [NMC-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, expv);
    end
  endtask

  function automatic logic b_term(logic [FW-1:0] f, logic [NLIT-1:0] lv);
    logic any;
    any = 1'b0;
    for (int i = 0; i < NLIT; i++) begin
      if (f[2*i]) begin any = 1'b1; if (!lv[i]) return 1'b0; end
      if (f[2*i+1]) begin any = 1'b1; if (lv[i]) return 1'b0; end
    end
    return any;
  endfunction

  task automatic clear_cfg();
    nx_in = '0; nx_fuse = '0; nx_route = '0; nx_lend = '0; nx_pol = '0;
  endtask

  task automatic set_lit(input int m, input int k, input int lit, input int neg);
    nx_fuse[(m*PT_PER_MC + k)*FW + 2*lit + neg] = 1'b1;
  endtask

  // set-based model: a receiver gathers terms from the lender run below it
  task automatic drive(input string tag, input logic want_err);
    exp_t e;
    logic [NMC-1:0] xl;
    logic [NLIT-1:0] lv;
    logic t [NMC][PT_PER_MC];
    logic acc;
    @(negedge clk);
    array_in = nx_in; fuse_map = nx_fuse; route_sel = nx_route;
    lend_en = nx_lend; pol_inv = nx_pol;
    for (int j = 0; j < NMC; j++) begin
      lv = {{NMC{1'b0}}, nx_in};
      xl[j] = nx_route[j*PT_PER_MC+4] ? ~b_term(nx_fuse[(j*PT_PER_MC+4)*FW +: FW] & {{(2*NMC){1'b0}}, {(2*NIN){1'b1}}}, lv) : 1'b1;
    end
    lv = {xl, nx_in};
    for (int m = 0; m < NMC; m++)
      for (int k = 0; k < PT_PER_MC; k++)
        t[m][k] = b_term(nx_fuse[(m*PT_PER_MC+k)*FW +: FW], lv);
    for (int m = 0; m < NMC; m++) begin
      if (nx_lend[m]) e.sum[m] = nx_pol[m];
      else begin
        int d;
        acc = 1'b0;
        for (int k = 0; k < PT_PER_MC; k++) if (!nx_route[m*PT_PER_MC+k]) acc |= t[m][k];
        d = m - 1;
        while (d >= 0) begin
          if (!nx_lend[d]) break;
          for (int k = 0; k < PT_PER_MC; k++) acc |= t[d][k];
          d--;
        end
        e.sum[m] = acc ^ nx_pol[m];
      end
      e.clr[m]  = nx_route[m*PT_PER_MC+0] ? t[m][0] : 1'b0;
      e.pre[m]  = nx_route[m*PT_PER_MC+1] ? t[m][1] : 1'b0;
      e.clkc[m] = nx_route[m*PT_PER_MC+2] ? t[m][2] : 1'b0;
      e.ce[m]   = nx_route[m*PT_PER_MC+3] ? t[m][3] : 1'b1;
    end
    e.err = want_err;
    e.full = !want_err;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.err ? "R7 cfg_err" : {e.tag, " cfg_err"}, {{(NMC-1){1'b0}}, cfg_err}, {{(NMC-1){1'b0}}, e.err});
        if (e.full) begin
          chk({e.tag, " sum"}, mc_sum, e.sum);
          chk("R2 clr", reg_clr, e.clr);
          chk("R2 pre", reg_pre, e.pre);
          chk("R2 clk", reg_clk, e.clkc);
          chk("R2 ce", reg_ce, e.ce);
        end
      end
    end
  end

  task automatic random_legal();
    int run;
    bit b;
    clear_cfg();
    run = 0;
    for (int m = 0; m < NMC - 1; m++) begin
      b = ($urandom % 3) == 0;
      if (b && run == MAX_LENDERS) b = 0;
      nx_lend[m] = b;
      run = b ? run + 1 : 0;
    end
    for (int i = 0; i < NT; i++)
      nx_route[i] = nx_lend[i / PT_PER_MC] ? 1'b0 : (($urandom % 4) == 0);
    for (int m = 0; m < NMC; m++)
      for (int k = 0; k < PT_PER_MC; k++) begin
        int n;
        n = $urandom % 3;
        for (int q = 0; q < n; q++) begin
          int lit;
          lit = (k == 4 && nx_route[m*PT_PER_MC+4]) ? int'($urandom % NIN) : int'($urandom % NLIT);
          set_lit(m, k, lit, int'($urandom % 2));
        end
      end
    nx_pol = NMC'($urandom);
    nx_in = NIN'($urandom);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    pol_inv = '1;
    repeat (3) @(negedge clk);
    // R8: reset holds outputs low even with inverting polarity applied
    chk("R8 reset sum", mc_sum, '0);
    chk("R8 reset ce", reg_ce, '0);
    chk("R8 reset err", {{(NMC-1){1'b0}}, cfg_err}, '0);
    rst_n = 1'b1;

    // R1: unfused terms are inactive
    clear_cfg(); drive("R1", 1'b0);
    nx_pol = '1; drive("R4", 1'b0);
    nx_pol = 8'b0101_0011; drive("R4", 1'b0);

    // R1: complemented literal
    clear_cfg(); set_lit(0, 0, 0, 1);
    nx_in = 6'b000000; drive("R1", 1'b0);
    nx_in = 6'b000001; drive("R1", 1'b0);
    clear_cfg(); set_lit(3, 2, 4, 0); set_lit(3, 2, 5, 1);
    nx_in = 6'b010000; drive("R1", 1'b0);
    nx_in = 6'b110000; drive("R1", 1'b0);

    // R2: secondary roles
    clear_cfg();
    for (int k = 0; k < 4; k++) begin set_lit(1, k, 2, 0); nx_route[1*PT_PER_MC + k] = 1'b1; end
    nx_in = 6'b000100; drive("R2", 1'b0);
    nx_in = 6'b000000; drive("R2", 1'b0);

    // R3: shared expander feeds another macrocell complemented
    clear_cfg();
    set_lit(2, 4, 1, 0); nx_route[2*PT_PER_MC + 4] = 1'b1;
    set_lit(5, 0, NIN + 2, 1);
    nx_in = 6'b000010; drive("R3", 1'b0);
    nx_in = 6'b000000; drive("R3", 1'b0);

    // R5/R6: three lenders into macrocell 7
    clear_cfg();
    nx_lend[4] = 1'b1; nx_lend[5] = 1'b1; nx_lend[6] = 1'b1;
    set_lit(4, 2, 0, 0);
    nx_in = 6'b000001; drive("R6", 1'b0);
    nx_in = 6'b000000; drive("R6", 1'b0);
    nx_pol = 8'b0111_0000; nx_in = 6'b000001; drive("R5", 1'b0);
    clear_cfg(); nx_lend[0] = 1'b1; set_lit(0, 4, 3, 0);
    nx_in = 6'b001000; drive("R5", 1'b0);

    // R7: illegal settings
    clear_cfg(); nx_lend[NMC-1] = 1'b1; drive("R7", 1'b1);
    clear_cfg(); nx_lend[3:0] = 4'b1111; drive("R7", 1'b1);
    clear_cfg(); nx_lend[2] = 1'b1; nx_route[2*PT_PER_MC + 1] = 1'b1; drive("R7", 1'b1);
    clear_cfg(); nx_route[3*PT_PER_MC + 4] = 1'b1; set_lit(3, 4, NIN + 3, 0); drive("R7", 1'b1);
    clear_cfg(); nx_lend[2:0] = 3'b111; drive("R7", 1'b0);

    // random legal configurations
    for (int it = 0; it < 400; it++) begin
      random_legal();
      drive("R6", 1'b0);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule